// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block buffers 36-bit words between two unrelated clock domains. The producer side writes on its own clock and the consumer side reads on another. Each side has a pair of enables, and a transfer happens only when both enables are high. The default capacity is 1024 words. A smaller power-of-two depth can be chosen by parameter, for example for fast simulation.

The write side drives three flags: full, almost-full and half-full. The read side drives two: empty and almost-empty. Every flag is a register clocked in the domain that consumes it. The pointers cross between the domains as Gray code through two-flop synchronisers. A flag can therefore stay in its cautious state for a few cycles after the far side has moved.

The almost-full and almost-empty margins start at eight after reset. Either side can reload either margin while the FIFO runs.

Top module: `dcfifo_flags`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge only when `wr_en_a` and `wr_en_b` are both 1 and `wr_full` is 0. With only one write enable high, nothing is stored.
- R2: A word is removed on a rising `rd_clk` edge only when `rd_en_a` and `rd_en_b` are both 1 and `rd_empty` is 0. The removed word appears on `rd_data` after that same edge, and words leave in the order they were written. With only one read enable high, nothing is removed.
- R3: A write attempt while `wr_full` is 1 is dropped. The stored contents and the write pointer stay unchanged.
- R4: A read attempt while `rd_empty` is 1 is dropped. The read pointer stays unchanged, so the next word written is the next word read.
- R5: `wr_full` is 1 when the write side sees DEPTH words stored. It clears within a few `wr_clk` cycles after a read frees a slot.
- R6: `rd_empty` is 1 when the read side sees zero words stored. It clears within a few `rd_clk` cycles after a write.
- R7: `wr_half` is 1 when the write side sees at least DEPTH/2 words stored.
- R8: `wr_afull` is 1 when the free slots seen by the write side are no more than the almost-full margin.
- R9: `rd_aempty` is 1 when the words seen by the read side are no more than the almost-empty margin.
- R10: A pulse on `wr_cfg_ld` or `rd_cfg_ld` loads the value on the matching `*_cfg_val` into a margin. A select of 0 means the almost-empty margin and a select of 1 means the almost-full margin. The new margin reaches the flag's domain within eight cycles of the slower clock. Successive loads must be spaced at least that far apart.
- R11: While `rst_n` is low, the block is held in its reset state, and the synchronised release leaves it there. Both pointers are zero, both margins are 8, `rd_empty`=1, `rd_aempty`=1, `wr_full`=0, `wr_half`=0 and `wr_afull`=0 (for DEPTH above 8).
- R12: The Gray-coded pointers change in at most one bit per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | DW | Word to store |
| wr_cfg_ld | input | 1 | Margin load strobe, write side |
| wr_cfg_sel | input | 1 | Margin select for a write-side load (0 almost-empty, 1 almost-full) |
| wr_cfg_val | input | AW+1 | Margin value for a write-side load |
| wr_full | output | 1 | FIFO full |
| wr_afull | output | 1 | Free slots at or below the almost-full margin |
| wr_half | output | 1 | At least half the depth in use |
| rd_clk | input | 1 | Read-side clock |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_data | output | DW | Word most recently read |
| rd_cfg_ld | input | 1 | Margin load strobe, read side |
| rd_cfg_sel | input | 1 | Margin select for a read-side load (0 almost-empty, 1 almost-full) |
| rd_cfg_val | input | AW+1 | Margin value for a read-side load |
| rd_empty | output | 1 | FIFO empty |
| rd_aempty | output | 1 | Stored words at or below the almost-empty margin |

## Verification
The bench first drives each enable of a pair alone and expects no transfer. A design that ORed the enables would store or drop a word, and the flags and the read-back order would then show it.

It fills the FIFO to DEPTH and pushes two more words. A design that wraps its pointer would overwrite old data or make the FIFO look empty, so the drain order would break. It also reads from an empty FIFO and then writes one word. A design that lets the read pointer slip would return the wrong word or report spurious data.

The flags are probed exactly at their thresholds, both with the default margins and after margins are loaded from the side that does not own the flag. A design with an off-by-one comparison, or one whose margins never cross domains, would give the wrong flag value at one of those counts.

// File: rtl/dcfifo_flags_pkg.sv
package dcfifo_flags_pkg;
  // Margin select encoding shared by both configuration ports.
  typedef enum logic {
    SEL_AEMPTY = 1'b0,
    SEL_AFULL  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/dcfifo_rst_sync.sv
// Asynchronous assert, synchronous release reset for one domain.
module dcfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dcfifo_sync2.sv
// Two-flop synchroniser for a vector whose bits are safe to sample
// independently (Gray code or a single toggle).
module dcfifo_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/dcfifo_ram.sv
// Simple dual-clock storage with a registered read port.
module dcfifo_ram #(
  parameter int DW = 36,
  parameter int AW = 10
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wr_clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata_q <= mem_q[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dcfifo_ofs_bank.sv
// Holds the one margin its domain consumes. A local load for the
// other margin is handed across via a toggle and a held value.
module dcfifo_ofs_bank
  import dcfifo_flags_pkg::*;
#(
  parameter int       PW      = 11,
  parameter int       DEF_OFS = 8,
  parameter ofs_sel_e OWN_SEL = SEL_AEMPTY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_ld,
  input  logic          loc_sel,
  input  logic [PW-1:0] loc_val,
  input  logic          rem_tgl,
  input  logic [PW-1:0] rem_val,
  output logic [PW-1:0] own_ofs,
  output logic          tx_tgl,
  output logic [PW-1:0] tx_val
);
  logic          rem_s;
  logic          rem_prev_q;
  logic          rem_edge;
  logic [PW-1:0] own_q, own_d;
  logic          txt_q, txt_d;
  logic [PW-1:0] txv_q, txv_d;

  dcfifo_sync2 #(.W(1)) u_tgl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rem_tgl),
    .q    (rem_s)
  );

  assign rem_edge = rem_s ^ rem_prev_q;

  always_comb begin
    own_d = own_q;
    txt_d = txt_q;
    txv_d = txv_q;
    if (rem_edge) own_d = rem_val;
    if (loc_ld) begin
      if (loc_sel == OWN_SEL) begin
        own_d = loc_val;
      end else begin
        txt_d = ~txt_q;
        txv_d = loc_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_prev_q <= 1'b0;
      own_q      <= PW'(DEF_OFS);
      txt_q      <= 1'b0;
      txv_q      <= PW'(DEF_OFS);
    end else begin
      rem_prev_q <= rem_s;
      own_q      <= own_d;
      txt_q      <= txt_d;
      txv_q      <= txv_d;
    end
  end

  assign own_ofs = own_q;
  assign tx_tgl  = txt_q;
  assign tx_val  = txv_q;
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
  import dcfifo_flags_pkg::*;
#(
  parameter int DW      = 36,
  parameter int AW      = 10,
  parameter int DEF_OFS = 8
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en_a,
  input  logic          wr_en_b,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_cfg_ld,
  input  logic          wr_cfg_sel,
  input  logic [AW:0]   wr_cfg_val,
  output logic          wr_full,
  output logic          wr_afull,
  output logic          wr_half,
  input  logic          rd_clk,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  output logic [DW-1:0] rd_data,
  input  logic          rd_cfg_ld,
  input  logic          rd_cfg_sel,
  input  logic [AW:0]   rd_cfg_val,
  output logic          rd_empty,
  output logic          rd_aempty
);
  localparam int          PW    = AW + 1;
  localparam int          DEPTH = 1 << AW;
  localparam logic [PW-1:0] CAP  = PW'(DEPTH);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- resets ----------------
  logic wrst_n, rrst_n;

  dcfifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  dcfifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  // ---------------- margins ----------------
  logic [PW-1:0] af_ofs, ae_ofs;
  logic          w_tx_tgl, r_tx_tgl;
  logic [PW-1:0] w_tx_val, r_tx_val;

  dcfifo_ofs_bank #(.PW(PW), .DEF_OFS(DEF_OFS), .OWN_SEL(SEL_AFULL)) u_wbank (
    .clk    (wr_clk),
    .rst_n  (wrst_n),
    .loc_ld (wr_cfg_ld),
    .loc_sel(wr_cfg_sel),
    .loc_val(wr_cfg_val),
    .rem_tgl(r_tx_tgl),
    .rem_val(r_tx_val),
    .own_ofs(af_ofs),
    .tx_tgl (w_tx_tgl),
    .tx_val (w_tx_val)
  );

  dcfifo_ofs_bank #(.PW(PW), .DEF_OFS(DEF_OFS), .OWN_SEL(SEL_AEMPTY)) u_rbank (
    .clk    (rd_clk),
    .rst_n  (rrst_n),
    .loc_ld (rd_cfg_ld),
    .loc_sel(rd_cfg_sel),
    .loc_val(rd_cfg_val),
    .rem_tgl(w_tx_tgl),
    .rem_val(w_tx_val),
    .own_ofs(ae_ofs),
    .tx_tgl (r_tx_tgl),
    .tx_val (r_tx_val)
  );

  // ---------------- write domain ----------------
  logic          wr_go;
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rgray_s, rbin_s, wcnt_d;
  logic          full_q, full_d, afull_q, afull_d, half_q, half_d;

  dcfifo_sync2 #(.W(PW)) u_rptr_sync (
    .clk(wr_clk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_s)
  );

  always_comb begin
    wr_go   = wr_en_a & wr_en_b & ~full_q;
    wbin_d  = wbin_q + PW'(wr_go);
    wgray_d = b2g(wbin_d);
    rbin_s  = g2b(rgray_s);
    wcnt_d  = wbin_d - rbin_s;
    full_d  = (wcnt_d == CAP);
    afull_d = ((CAP - wcnt_d) <= af_ofs);
    half_d  = (wcnt_d >= HALF);
  end

  always_ff @(posedge wr_clk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      afull_q <= afull_d;
      half_q  <= half_d;
    end
  end

  // ---------------- read domain ----------------
  logic          rd_go;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wgray_s, wbin_s, rcnt_d;
  logic          empty_q, empty_d, aempty_q, aempty_d;

  dcfifo_sync2 #(.W(PW)) u_wptr_sync (
    .clk(rd_clk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_s)
  );

  always_comb begin
    rd_go    = rd_en_a & rd_en_b & ~empty_q;
    rbin_d   = rbin_q + PW'(rd_go);
    rgray_d  = b2g(rbin_d);
    wbin_s   = g2b(wgray_s);
    rcnt_d   = wbin_s - rbin_d;
    empty_d  = (rcnt_d == '0);
    aempty_d = (rcnt_d <= ae_ofs);
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      rbin_q   <= rbin_d;
      rgray_q  <= rgray_d;
      empty_q  <= empty_d;
      aempty_q <= aempty_d;
    end
  end

  // ---------------- storage ----------------
  dcfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wr_clk(wr_clk),
    .we    (wr_go),
    .waddr (wbin_q[AW-1:0]),
    .wdata (wr_data),
    .rd_clk(rd_clk),
    .re    (rd_go),
    .raddr (rbin_q[AW-1:0]),
    .rdata (rd_data)
  );

  assign wr_full   = full_q;
  assign wr_afull  = afull_q;
  assign wr_half   = half_q;
  assign rd_empty  = empty_q;
  assign rd_aempty = aempty_q;
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int AW = 10
) (
  input logic        wr_clk,
  input logic        wrst_n,
  input logic        rd_clk,
  input logic        rrst_n,
  input logic        wr_en_a,
  input logic        wr_en_b,
  input logic        rd_en_a,
  input logic        rd_en_b,
  input logic        wr_full,
  input logic        wr_afull,
  input logic        wr_half,
  input logic        rd_empty,
  input logic        rd_aempty,
  input logic [AW:0] wbin_q,
  input logic [AW:0] rbin_q,
  input logic [AW:0] wgray_q,
  input logic [AW:0] rgray_q,
  input logic [AW:0] rbin_s
);
  localparam logic [AW:0] CAP = (AW+1)'(1 << AW);

  assert_wr_gate_R1: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    !(wr_en_a && wr_en_b) |=> $stable(wbin_q));

  assert_rd_gate_R2: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    !(rd_en_a && rd_en_b) |=> $stable(rbin_q));

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_full && wr_en_a && wr_en_b) |=> $stable(wbin_q));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_empty && rd_en_a && rd_en_b) |=> $stable(rbin_q));

  assert_count_bound_R5: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wbin_q - rbin_s) <= CAP);

  assert_full_half_R7: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    wr_full |-> wr_half);

  assert_full_afull_R8: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    wr_full |-> wr_afull);

  assert_empty_aempty_R9: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    rd_empty |-> rd_aempty);

  assert_wgray_step_R12: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));

  assert_rgray_step_R12: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.AW(AW)) chk_i (
  .wr_clk   (wr_clk),
  .wrst_n   (wrst_n),
  .rd_clk   (rd_clk),
  .rrst_n   (rrst_n),
  .wr_en_a  (wr_en_a),
  .wr_en_b  (wr_en_b),
  .rd_en_a  (rd_en_a),
  .rd_en_b  (rd_en_b),
  .wr_full  (wr_full),
  .wr_afull (wr_afull),
  .wr_half  (wr_half),
  .rd_empty (rd_empty),
  .rd_aempty(rd_aempty),
  .wbin_q   (wbin_q),
  .rbin_q   (rbin_q),
  .wgray_q  (wgray_q),
  .rgray_q  (rgray_q),
  .rbin_s   (rbin_s)
);

// File: tb/dcfifo_flags_tb_top.sv
module dcfifo_flags_tb_top;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          rst_n;
  logic          wr_clk, rd_clk;
  logic          wr_en_a, wr_en_b, rd_en_a, rd_en_b;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_cfg_ld, wr_cfg_sel, rd_cfg_ld, rd_cfg_sel;
  logic [AW:0]   wr_cfg_val, rd_cfg_val;
  logic          wr_full, wr_afull, wr_half, rd_empty, rd_aempty;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];
  logic          acc_q;

  dcfifo_flags #(.DW(DW), .AW(AW), .DEF_OFS(8)) dut_i (
    .rst_n(rst_n),
    .wr_clk(wr_clk), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
    .wr_cfg_ld(wr_cfg_ld), .wr_cfg_sel(wr_cfg_sel), .wr_cfg_val(wr_cfg_val),
    .wr_full(wr_full), .wr_afull(wr_afull), .wr_half(wr_half),
    .rd_clk(rd_clk), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_data(rd_data),
    .rd_cfg_ld(rd_cfg_ld), .rd_cfg_sel(rd_cfg_sel), .rd_cfg_val(rd_cfg_val),
    .rd_empty(rd_empty), .rd_aempty(rd_aempty)
  );

  // 50 MHz on both sides, read clock offset in phase
  initial begin
    wr_clk = 1'b0;
    forever #10 wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 1'b0;
    #7;
    forever #10 rd_clk = ~rd_clk;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_errors++;
    $display("FAIL watchdog: act=timeout exp=completion");
    summary();
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  // Scoreboard monitor: acceptance seen at the read edge, data sampled at the falling edge
  always @(posedge rd_clk) acc_q <= rd_en_a && rd_en_b && !rd_empty;

  always @(negedge rd_clk) begin
    if (acc_q === 1'b1) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R4 read with nothing expected: act=%h exp=none", rd_data);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          n_errors++;
          $display("FAIL R2 order/data: act=%h exp=%h", rd_data, e);
        end
      end
    end
  end

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en_a = 1; wr_en_b = 1; wr_data = d;
    if (!wr_full) exp_q.push_back(d);
    @(negedge wr_clk);
    wr_en_a = 0; wr_en_b = 0;
  endtask

  task automatic rd_word();
    @(negedge rd_clk);
    rd_en_a = 1; rd_en_b = 1;
    @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge wr_clk);
  endtask

  task automatic wr_load(input logic sel, input logic [AW:0] v);
    @(negedge wr_clk);
    wr_cfg_ld = 1; wr_cfg_sel = sel; wr_cfg_val = v;
    @(negedge wr_clk);
    wr_cfg_ld = 0;
    settle();
  endtask

  task automatic rd_load(input logic sel, input logic [AW:0] v);
    @(negedge rd_clk);
    rd_cfg_ld = 1; rd_cfg_sel = sel; rd_cfg_val = v;
    @(negedge rd_clk);
    rd_cfg_ld = 0;
    settle();
  endtask

  task automatic chk_queue_empty(input string req);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL %s: act=%0d words pending exp=0", req, exp_q.size());
    end
  endtask

  initial begin
    rst_n = 0;
    wr_en_a = 0; wr_en_b = 0; wr_data = '0;
    rd_en_a = 0; rd_en_b = 0;
    wr_cfg_ld = 0; wr_cfg_sel = 0; wr_cfg_val = '0;
    rd_cfg_ld = 0; rd_cfg_sel = 0; rd_cfg_val = '0;
    repeat (4) @(negedge wr_clk);
    rst_n = 1;
    settle();

    // R11 reset state
    chk("R11 empty", rd_empty, 1'b1);
    chk("R11 aempty", rd_aempty, 1'b1);
    chk("R11 full", wr_full, 1'b0);
    chk("R11 afull", wr_afull, 1'b0);
    chk("R11 half", wr_half, 1'b0);

    // R1: a single write enable never stores
    @(negedge wr_clk); wr_en_a = 1; wr_data = 36'h111111111;
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 1;
    @(negedge wr_clk); wr_en_b = 0;
    settle();
    chk("R1 single enable no write", rd_empty, 1'b1);

    // R6: one word clears empty
    wr_word(36'h0A5A5A5A5);
    settle();
    chk("R6 empty clears", rd_empty, 1'b0);

    // R2: a single read enable never removes
    @(negedge rd_clk); rd_en_a = 1;
    @(negedge rd_clk); rd_en_a = 0; rd_en_b = 1;
    @(negedge rd_clk); rd_en_b = 0;
    settle();
    chk("R2 single enable no read", rd_empty, 1'b0);
    rd_word();
    settle();
    chk("R6 empty after drain", rd_empty, 1'b1);
    chk_queue_empty("R2 word delivered");

    // R4: reads while empty are dropped
    rd_word();
    rd_word();
    wr_word(36'h0ABC00DEF);
    settle();
    rd_word();
    settle();
    chk_queue_empty("R4 pointer unchanged");

    // R7/R8/R9 at default margins (8)
    for (int i = 0; i < 7; i++) wr_word(36'h100 + 36'(i));
    settle();
    chk("R9 aempty at 7", rd_aempty, 1'b1);
    chk("R8 afull at 7 (free 9)", wr_afull, 1'b0);
    chk("R7 half at 7", wr_half, 1'b0);
    wr_word(36'h107);
    settle();
    chk("R9 aempty at 8", rd_aempty, 1'b1);
    chk("R8 afull at 8 (free 8)", wr_afull, 1'b1);
    chk("R7 half at 8", wr_half, 1'b1);
    wr_word(36'h108);
    settle();
    chk("R9 aempty at 9", rd_aempty, 1'b0);

    // R5 / R3: fill and overfill
    for (int i = 9; i < DEPTH; i++) wr_word(36'h100 + 36'(i));
    settle();
    chk("R5 full at depth", wr_full, 1'b1);
    wr_word(36'hDEAD0001);
    wr_word(36'hDEAD0002);
    settle();
    chk("R3 full held", wr_full, 1'b1);
    rd_word();
    settle();
    chk("R5 full clears", wr_full, 1'b0);
    wr_word(36'h200);
    settle();
    chk("R5 full again", wr_full, 1'b1);
    for (int i = 0; i < DEPTH; i++) rd_word();
    settle();
    chk("R6 empty after full drain", rd_empty, 1'b1);
    chk_queue_empty("R3 overflow words dropped");

    // R10: margins loaded from the side that does not own the flag
    wr_load(1'b0, 5'd3);   // almost-empty margin via write side
    rd_load(1'b1, 5'd2);   // almost-full margin via read side
    for (int i = 0; i < 3; i++) wr_word(36'h300 + 36'(i));
    settle();
    chk("R10 aempty at 3 margin 3", rd_aempty, 1'b1);
    wr_word(36'h303);
    settle();
    chk("R10 aempty at 4 margin 3", rd_aempty, 1'b0);
    for (int i = 4; i < 13; i++) wr_word(36'h300 + 36'(i));
    settle();
    chk("R10 afull at 13 margin 2", wr_afull, 1'b0);
    wr_word(36'h30D);
    settle();
    chk("R10 afull at 14 margin 2", wr_afull, 1'b1);
    // same-side loads
    wr_load(1'b1, 5'd0);
    chk("R10 afull margin 0 at 14", wr_afull, 1'b0);
    rd_load(1'b0, 5'd15);
    chk("R10 aempty margin 15 at 14", rd_aempty, 1'b1);
    for (int i = 0; i < 14; i++) rd_word();
    settle();
    chk("R6 empty end", rd_empty, 1'b1);
    chk_queue_empty("R2 final order");

    summary();
  end
endmodule